// File: doc/BRIEF.md
# Software Flow-Control Character Detector

This block sits beside a UART receiver. It looks at every received character and decides three things: whether the local transmitter must pause, whether the character goes into the receive data FIFO, and whether a flow event has occurred that the host should see. Four programmable match characters are held in the block: two resume characters (first and second) and two pause characters (first and second). Matching can use one character or a pair of back-to-back characters. An optional mode lets any received character end a pause. A separate detect-only mode flags one chosen character without filtering it out.

The pause request reaches the transmitter only on a character boundary, so a character already on the line is always sent in full. Characters that form a pause or resume match are removed from the data stream. A pair that starts to match but then breaks is handed to the FIFO in arrival order. Two write lanes are provided so that both characters can be written in the same cycle.

Top module: `xonxoff_flow_detect`

## Requirements
- R1: After reset the transmit hold, the flow flag, the interrupt and both FIFO write enables are low, and all four match registers and the mode register read as zero. With flow control enabled and no registers written, a received 0x00 therefore counts as a pause character.
- R2: In single-character mode (mode bit0=1, bit1=0), while the block is not paused, a character equal to pause-first (address 2) causes a pause and sets the flow flag. That character is not written to the FIFO.
- R3: While paused, a character equal to resume-first (address 0) ends the pause, clears the flow flag and is not written to the FIFO. While paused, other characters, including pause characters, are written as data.
- R4: tx_hold only changes on a cycle where tx_boundary is high. On that cycle it takes the paused state, including the effect of any character received in the same cycle.
- R5: In pair mode (bit1=1), a pause needs pause-first immediately followed by pause-second (address 3), and a resume needs resume-first immediately followed by resume-second (address 1). Neither character of a completed pair is written to the FIFO.
- R6: In pair mode, if the character after a held first character does not complete the pair, the held character is written on lane 0 and the new character on lane 1 in the same cycle. The exception is when the new character is itself a first character: it is then held and lane 1 stays idle. Lane 1 never writes without lane 0.
- R7: With resume-on-any (bit2=1), any character received while paused ends the pause, clears the flow flag and is written to the FIFO. Pausing works as in R2.
- R8: Only the low N bits are compared, where N = 5, 6, 7 or 8 for wlen = 0, 1, 2 or 3. Register bit 0 lines up with received bit 0.
- R9: In detect-only mode (bit3=1, bit0=0), every character is written to the FIFO. A character equal to pause-second sets the flow flag and does not pause the transmitter.
- R10: irq is high exactly when the flow flag is set and irq_en is high. A status_clr pulse clears the flag. If a flag-setting character arrives in the same cycle, the set wins.
- R11: A character that is written to the FIFO appears unchanged on wr_data0, with wr_en0 high, in the cycle after rx_valid. No write happens without a received character.
- R12: With bit0=0 and bit3=0, every character is written to the FIFO and neither tx_hold nor the flow flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | 0 resume-first, 1 resume-second, 2 pause-first, 3 pause-second, 4 mode |
| cfg_wdata | input | 8 | Configuration write data; mode bits: 0 enable, 1 pair, 2 resume-on-any, 3 detect-only |
| wlen | input | 2 | Word length code, N = 5 + wlen |
| rx_valid | input | 1 | Received-character strobe |
| rx_data | input | 8 | Received character |
| tx_boundary | input | 1 | Transmitter is between characters |
| status_clr | input | 1 | Host read of interrupt status; clears the flow flag |
| irq_en | input | 1 | Interrupt enable for flow events |
| tx_hold | output | 1 | Pause request to the transmitter |
| flow_flag | output | 1 | Flow event status |
| irq | output | 1 | Flow interrupt |
| wr_en0 | output | 1 | FIFO write, older character |
| wr_data0 | output | 8 | Data for lane 0 |
| wr_en1 | output | 1 | FIFO write, newer character |
| wr_data1 | output | 8 | Data for lane 1 |

## Verification
The FIFO writes and the flow flag are registered and are due one clock after the rx_valid cycle. tx_hold is due one clock after the tx_boundary cycle, and irq follows the flag with no extra delay. The bench drives each stimulus on a falling edge, removes it on the next falling edge, and samples the outputs at that point, which is exactly one rising edge later. Separate boundary pulses are used so that a pause can be seen both before and after it reaches the transmitter.

// File: rtl/flow_pkg.sv
package flow_pkg;
    localparam int unsigned CW = 8;

    localparam int unsigned IDX_ON1  = 0;
    localparam int unsigned IDX_ON2  = 1;
    localparam int unsigned IDX_OFF1 = 2;
    localparam int unsigned IDX_OFF2 = 3;
    localparam int unsigned NREG     = 4;
    localparam logic [2:0]  ADDR_MODE = 3'd4;

    typedef struct packed {
        logic special;
        logic any;
        logic pair;
        logic en;
    } mode_t;

    typedef struct packed {
        logic          susp;
        logic          hold;
        logic          flag;
        logic          pend;
        logic [CW-1:0] pend_data;
        logic          we0;
        logic [CW-1:0] d0;
        logic          we1;
        logic [CW-1:0] d1;
    } ctrl_t;
endpackage

// File: rtl/flow_regs.sv
module flow_regs
    import flow_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [2:0]               cfg_addr,
    input  logic [CW-1:0]            cfg_wdata,
    output logic [NREG-1:0][CW-1:0]  xreg,
    output mode_t                    mode
);
    logic [NREG-1:0][CW-1:0] xreg_d, xreg_q;
    mode_t                   mode_d, mode_q;

    always_comb begin
        xreg_d = xreg_q;
        mode_d = mode_q;
        if (cfg_we) begin
            if (cfg_addr == ADDR_MODE) begin
                mode_d = mode_t'(cfg_wdata[3:0]);
            end else if (int'(cfg_addr) < NREG) begin
                xreg_d[cfg_addr[1:0]] = cfg_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xreg_q <= '0;
            mode_q <= '0;
        end else begin
            xreg_q <= xreg_d;
            mode_q <= mode_d;
        end
    end

    assign xreg = xreg_q;
    assign mode = mode_q;
endmodule

// File: rtl/flow_cmp.sv
module flow_cmp
    import flow_pkg::*;
(
    input  logic [CW-1:0]            rx_data,
    input  logic [1:0]               wlen,
    input  logic [NREG-1:0][CW-1:0]  xreg,
    output logic [NREG-1:0]          hit
);
    localparam int unsigned MIN_BITS = 5;

    logic [CW-1:0] mask;
    assign mask = ~({CW{1'b1}} << (4'(wlen) + 4'(MIN_BITS)));

    for (genvar i = 0; i < NREG; i++) begin : g_cmp
        assign hit[i] = ((rx_data ^ xreg[i]) & mask) == '0;
    end
endmodule

// File: rtl/flow_ctrl.sv
module flow_ctrl
    import flow_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  mode_t           mode,
    input  logic [NREG-1:0] hit,
    input  logic            rx_valid,
    input  logic [CW-1:0]   rx_data,
    input  logic            tx_boundary,
    input  logic            status_clr,
    output ctrl_t           st
);
    ctrl_t st_d, st_q;
    logic  first_hit, second_hit;

    assign first_hit  = st_q.susp ? hit[IDX_ON1] : hit[IDX_OFF1];
    assign second_hit = st_q.susp ? hit[IDX_ON2] : hit[IDX_OFF2];

    always_comb begin
        st_d     = st_q;
        st_d.we0 = 1'b0;
        st_d.we1 = 1'b0;
        if (status_clr) st_d.flag = 1'b0;

        if (rx_valid) begin
            if (mode.en) begin
                if (st_q.susp && mode.any) begin
                    st_d.susp = 1'b0;
                    st_d.flag = 1'b0;
                    st_d.pend = 1'b0;
                    st_d.we0  = 1'b1;
                    st_d.d0   = rx_data;
                end else if (!mode.pair) begin
                    st_d.pend = 1'b0;
                    if (first_hit) begin
                        st_d.susp = !st_q.susp;
                        st_d.flag = !st_q.susp;
                    end else begin
                        st_d.we0 = 1'b1;
                        st_d.d0  = rx_data;
                    end
                end else if (st_q.pend) begin
                    if (second_hit) begin
                        st_d.susp = !st_q.susp;
                        st_d.flag = !st_q.susp;
                        st_d.pend = 1'b0;
                    end else begin
                        st_d.we0 = 1'b1;
                        st_d.d0  = st_q.pend_data;
                        if (first_hit) begin
                            st_d.pend_data = rx_data;
                        end else begin
                            st_d.we1  = 1'b1;
                            st_d.d1   = rx_data;
                            st_d.pend = 1'b0;
                        end
                    end
                end else if (first_hit) begin
                    st_d.pend      = 1'b1;
                    st_d.pend_data = rx_data;
                end else begin
                    st_d.we0 = 1'b1;
                    st_d.d0  = rx_data;
                end
            end else begin
                st_d.pend = 1'b0;
                st_d.we0  = 1'b1;
                st_d.d0   = rx_data;
                if (mode.special && hit[IDX_OFF2]) st_d.flag = 1'b1;
            end
        end

        if (tx_boundary) st_d.hold = st_d.susp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;
endmodule

// File: rtl/xonxoff_flow_detect.sv
module xonxoff_flow_detect
    import flow_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [7:0]    cfg_wdata,
    input  logic [1:0]    wlen,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          tx_boundary,
    input  logic          status_clr,
    input  logic          irq_en,
    output logic          tx_hold,
    output logic          flow_flag,
    output logic          irq,
    output logic          wr_en0,
    output logic [7:0]    wr_data0,
    output logic          wr_en1,
    output logic [7:0]    wr_data1
);
    logic [NREG-1:0][CW-1:0] xreg;
    mode_t                   mode;
    logic [NREG-1:0]         hit;
    ctrl_t                   st;

    flow_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .xreg      (xreg),
        .mode      (mode)
    );

    flow_cmp u_cmp (
        .rx_data (rx_data),
        .wlen    (wlen),
        .xreg    (xreg),
        .hit     (hit)
    );

    flow_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .hit         (hit),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .tx_boundary (tx_boundary),
        .status_clr  (status_clr),
        .st          (st)
    );

    assign tx_hold   = st.hold;
    assign flow_flag = st.flag;
    assign irq       = st.flag & irq_en;
    assign wr_en0    = st.we0;
    assign wr_data0  = st.d0;
    assign wr_en1    = st.we1;
    assign wr_data1  = st.d1;
endmodule

// File: rtl/flow_chk.sv
module flow_chk
    import flow_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic [7:0] rx_data,
    input logic       tx_boundary,
    input logic       status_clr,
    input logic       tx_hold,
    input logic       flow_flag,
    input logic       wr_en0,
    input logic [7:0] wr_data0,
    input logic       wr_en1,
    input mode_t      mode
);
    p_hold_on_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_boundary |=> $stable(tx_hold));

    p_lane_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en1 |-> wr_en0);

    p_write_needs_rx_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !wr_en0 && !wr_en1);

    p_passthrough_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !mode.en && !mode.special) |=>
            (wr_en0 && !wr_en1 && wr_data0 == $past(rx_data)));

    p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_clr && !rx_valid) |=> !flow_flag);
endmodule

bind xonxoff_flow_detect flow_chk u_flow_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .rx_data     (rx_data),
    .tx_boundary (tx_boundary),
    .status_clr  (status_clr),
    .tx_hold     (tx_hold),
    .flow_flag   (flow_flag),
    .wr_en0      (wr_en0),
    .wr_data0    (wr_data0),
    .wr_en1      (wr_en1),
    .mode        (mode)
);

// File: tb/tb_xonxoff_flow_detect.sv
module tb_xonxoff_flow_detect;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [1:0] wlen = 2'd3;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       tx_boundary = 1'b0;
    logic       status_clr = 1'b0;
    logic       irq_en = 1'b0;
    logic       tx_hold, flow_flag, irq, wr_en0, wr_en1;
    logic [7:0] wr_data0, wr_data1;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    xonxoff_flow_detect dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .wlen(wlen), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_boundary(tx_boundary), .status_clr(status_clr), .irq_en(irq_en),
        .tx_hold(tx_hold), .flow_flag(flow_flag), .irq(irq),
        .wr_en0(wr_en0), .wr_data0(wr_data0), .wr_en1(wr_en1), .wr_data1(wr_data1)
    );

    // data, stored, hold, flag ; single mode, resume 0x11, pause 0x13
    localparam logic [10:0] VEC [0:7] = '{
        {8'h41, 1'b1, 1'b0, 1'b0},
        {8'h13, 1'b0, 1'b1, 1'b1},
        {8'h42, 1'b1, 1'b1, 1'b1},
        {8'h13, 1'b1, 1'b1, 1'b1},
        {8'h11, 1'b0, 1'b0, 1'b0},
        {8'h11, 1'b1, 1'b0, 1'b0},
        {8'h13, 1'b0, 1'b1, 1'b1},
        {8'h11, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cfg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input logic b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d; tx_boundary = b;
        @(negedge clk);
        rx_valid = 1'b0; tx_boundary = 1'b0;
    endtask

    task automatic boundary();
        @(negedge clk);
        tx_boundary = 1'b1;
        @(negedge clk);
        tx_boundary = 1'b0;
    endtask

    task automatic std_regs();
        cfg(3'd0, 8'h11);
        cfg(3'd1, 8'h91);
        cfg(3'd2, 8'h13);
        cfg(3'd3, 8'h93);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog got=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, zeroed registers
        do_reset();
        @(negedge clk);
        chk("R1 hold", tx_hold, 0);
        chk("R1 flag", flow_flag, 0);
        chk("R1 irq", irq, 0);
        chk("R1 we0", wr_en0, 0);
        send(8'h00, 1'b0);
        chk("R1 mode cleared: stored", wr_en0, 1);
        cfg(3'd4, 8'h01);
        send(8'h00, 1'b1);
        chk("R1 zero pause: hold", tx_hold, 1);
        chk("R1 zero pause: not stored", wr_en0, 0);

        // R2 R3 R11: vector walk
        do_reset();
        std_regs();
        cfg(3'd4, 8'h01);
        for (int i = 0; i < 8; i++) begin
            send(VEC[i][10:3], 1'b1);
            chk($sformatf("R2/R3 vec%0d we0", i), wr_en0, VEC[i][2]);
            if (VEC[i][2]) chk($sformatf("R11 vec%0d data", i), wr_data0, VEC[i][10:3]);
            chk($sformatf("R2/R3 vec%0d hold", i), tx_hold, VEC[i][1]);
            chk($sformatf("R2/R3 vec%0d flag", i), flow_flag, VEC[i][0]);
        end

        // R4: hold follows boundary only
        send(8'h13, 1'b0);
        chk("R4 flag set", flow_flag, 1);
        chk("R4 hold waits", tx_hold, 0);
        boundary();
        chk("R4 hold at boundary", tx_hold, 1);
        send(8'h11, 1'b0);
        chk("R4 hold kept", tx_hold, 1);
        chk("R4 flag cleared", flow_flag, 0);
        boundary();
        chk("R4 hold released", tx_hold, 0);

        // R5 R6: pair mode
        do_reset();
        std_regs();
        cfg(3'd4, 8'h03);
        send(8'h13, 1'b1);
        chk("R5 first held", wr_en0, 0);
        chk("R5 no hold yet", tx_hold, 0);
        send(8'h93, 1'b1);
        chk("R5 pair pause", tx_hold, 1);
        chk("R5 pair discarded", wr_en0, 0);
        send(8'h11, 1'b1);
        chk("R6 resume-first held", wr_en0, 0);
        send(8'h41, 1'b1);
        chk("R6 lane0 we", wr_en0, 1);
        chk("R6 lane0 data", wr_data0, 8'h11);
        chk("R6 lane1 we", wr_en1, 1);
        chk("R6 lane1 data", wr_data1, 8'h41);
        chk("R6 still paused", tx_hold, 1);
        send(8'h11, 1'b1);
        send(8'h11, 1'b1);
        chk("R6 recheck lane0", wr_en0, 1);
        chk("R6 recheck lane0 data", wr_data0, 8'h11);
        chk("R6 recheck lane1 idle", wr_en1, 0);
        send(8'h91, 1'b1);
        chk("R6 recheck completes resume", tx_hold, 0);
        chk("R5 resume pair discarded", wr_en0, 0);

        // R7: resume on any
        do_reset();
        std_regs();
        cfg(3'd4, 8'h05);
        send(8'h13, 1'b1);
        chk("R7 pause", tx_hold, 1);
        send(8'h55, 1'b1);
        chk("R7 any resumes", tx_hold, 0);
        chk("R7 flag cleared", flow_flag, 0);
        chk("R7 stored", wr_en0, 1);
        chk("R7 data", wr_data0, 8'h55);

        // R8: word length masking
        do_reset();
        std_regs();
        cfg(3'd4, 8'h01);
        wlen = 2'd0;
        send(8'hF3, 1'b1);
        chk("R8 5-bit match", tx_hold, 1);
        chk("R8 5-bit discarded", wr_en0, 0);
        wlen = 2'd3;
        send(8'hF1, 1'b1);
        chk("R8 8-bit mismatch stored", wr_en0, 1);
        chk("R8 8-bit mismatch hold", tx_hold, 1);
        send(8'h11, 1'b1);
        chk("R8 8-bit match", tx_hold, 0);

        // R9 R10: detect-only mode and interrupt
        do_reset();
        std_regs();
        cfg(3'd4, 8'h08);
        send(8'h93, 1'b1);
        chk("R9 stored", wr_en0, 1);
        chk("R9 data", wr_data0, 8'h93);
        chk("R9 flag", flow_flag, 1);
        chk("R9 no hold", tx_hold, 0);
        chk("R10 irq masked", irq, 0);
        irq_en = 1'b1;
        #1;
        chk("R10 irq on", irq, 1);
        @(negedge clk);
        status_clr = 1'b1;
        @(negedge clk);
        status_clr = 1'b0;
        chk("R10 cleared", flow_flag, 0);
        chk("R10 irq off", irq, 0);
        @(negedge clk);
        status_clr = 1'b1; rx_valid = 1'b1; rx_data = 8'h93;
        @(negedge clk);
        status_clr = 1'b0; rx_valid = 1'b0;
        chk("R10 set wins", flow_flag, 1);
        irq_en = 1'b0;

        // R12: all off
        do_reset();
        std_regs();
        send(8'h13, 1'b1);
        chk("R12 stored", wr_en0, 1);
        chk("R12 data", wr_data0, 8'h13);
        chk("R12 hold", tx_hold, 0);
        chk("R12 flag", flow_flag, 0);
        @(negedge clk);
        chk("R11 no write idle", wr_en0, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule